// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a register-programmed 32-bit timer that counts down one step for every cycle in which an external tick strobe is high. Software writes a single control word holding a run bit, a repeat bit and a reload count. When the count runs out, the timer emits a one-cycle expiry pulse, meant to drive a downstream watchdog, and latches an interrupt flag. The flag holds until software writes one to it.

In repeat mode the count is restored from the reload field at each expiry, so expiries keep coming at a fixed interval. In single mode the timer clears its own run bit at expiry and stays idle. With a tick rate of 125000 strobes per second, a reload of 125000 gives one expiry per second. Writing zero to the control word halts the timer.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, and both `irq` and `expire_pulse` are low.
- R2: A write to byte offset 0x0 stores the run bit (bit 31), the repeat bit (bit 30) and the reload field (bits 28:0). Reading offset 0x0 returns them in the same positions, and bit 29 and any other unused bits read as 0.
- R3: A control write that sets bit 31 while the timer is halted loads the count with the written reload field. Offset 0x4 bits 28:0 return the current count.
- R4: In each cycle where `tick_en` is high, the timer is running and no control write occurs, the count drops by one.
- R5: A tick that arrives when the count is 1 or 0 is an expiry. `expire_pulse` is high in the following cycle, and status bit 30 is set. For a reload of N≥1 the expiry falls on the N-th tick after start; a reload of 0 expires on the first tick.
- R6: In repeat mode (bit 30 = 1) an expiry reloads the count from the reload field and leaves the run bit at 1.
- R7: In single mode (bit 30 = 0) an expiry sets the count to 0 and clears the run bit. Later ticks produce no pulse.
- R8: Writing 0 to offset 0x0 halts the timer. The count keeps its value, and ticks neither change it nor cause an expiry.
- R9: Writing offset 0x4 with bit 30 = 1 clears status bit 30. Such a write with bit 30 = 0 leaves it unchanged. `irq` equals status bit 30.
- R10: When an expiry and a clearing status write fall in the same cycle, the status bit ends up set.
- R11: A control write with bit 31 = 1 while the timer is already running does not restart the count. The new reload value takes effect at the next repeat reload.
- R12: A tick in the same cycle as a control write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset (0x0 control, 0x4 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| tick_en | input | 1 | Tick strobe, one count per high cycle |
| expire_pulse | output | 1 | One-cycle pulse per expiry |
| irq | output | 1 | Level interrupt, high while status bit 30 is set |

## Verification
Register writes and ticks take effect at the clock edge that samples them. So the new count, the expiry pulse and `irq` are all visible in the cycle right after the strobe, and `reg_rdata` follows `reg_addr` within the same cycle. The bench drives every strobe on a falling edge and drops it on the next falling edge. It samples `expire_pulse` and `irq` at that second falling edge, exactly one register stage after the strobe. Reads are taken a step after the address settles. Collisions between writes and ticks are driven in a single cycle, so the same-edge priority rules are exercised directly.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W    = 29,
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tick_en,
  output logic              expire_pulse,
  output logic              irq
);
  localparam int RUN_BIT = 31;
  localparam int REP_BIT = 30;
  localparam int IRQ_BIT = 30;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic             run_q, rep_q, irq_q, pulse_q;
  logic [CNT_W-1:0] reload_q, cnt_q;

  wire wr      = reg_valid && reg_write;
  wire wr_ctrl = wr && (reg_addr == CTRL_A);
  wire wr_stat = wr && (reg_addr == STAT_A);
  wire step    = run_q && tick_en && !wr_ctrl;
  wire fire    = step && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      rep_q    <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (wr_ctrl) begin
        run_q    <= reg_wdata[RUN_BIT];
        rep_q    <= reg_wdata[REP_BIT];
        reload_q <= reg_wdata[CNT_W-1:0];
        if (reg_wdata[RUN_BIT] && !run_q)
          cnt_q <= reg_wdata[CNT_W-1:0];
      end else if (step) begin
        if (cnt_q <= ONE) begin
          if (rep_q) begin
            cnt_q <= reload_q;
          end else begin
            cnt_q <= '0;
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
      if (fire)
        irq_q <= 1'b1;
      else if (wr_stat && reg_wdata[IRQ_BIT])
        irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata[RUN_BIT]   = run_q;
      reg_rdata[REP_BIT]   = rep_q;
      reg_rdata[CNT_W-1:0] = reload_q;
    end else if (reg_addr == STAT_A) begin
      reg_rdata[IRQ_BIT]   = irq_q;
      reg_rdata[CNT_W-1:0] = cnt_q;
    end
  end

  assign expire_pulse = pulse_q;
  assign irq          = irq_q;
endmodule

module tick_timer_chk #(
  parameter int CNT_W    = 29,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              tick_en,
  input logic              expire_pulse,
  input logic              irq,
  input logic              run_q,
  input logic              rep_q,
  input logic [CNT_W-1:0]  cnt_q
);
  assert_pulse_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> $past(tick_en));
  assert_pulse_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> irq);
  assert_irq_rise_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> expire_pulse);
  assert_irq_fall_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_valid && reg_write && reg_addr == ADDR_W'(STAT_OFS) && reg_wdata[30]));
  assert_count_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_en) && !$past(reg_valid && reg_write)) |-> $stable(cnt_q));
  assert_halted_no_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_q) |-> !expire_pulse);
  assert_single_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_pulse && !rep_q) |-> (!run_q && cnt_q == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tick_en(tick_en),
  .expire_pulse(expire_pulse), .irq(irq), .run_q(run_q), .rep_q(rep_q), .cnt_q(cnt_q)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0, tick_en = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        expire_pulse, irq;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  localparam int unsigned VREL[4] = '{3, 1, 0, 6};
  localparam bit          VPER[4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int unsigned VEXP[4] = '{3, 1, 1, 6};

  always #4 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_en(tick_en), .expire_pulse(expire_pulse), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick(output logic p);
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    p = expire_pulse;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); check(v == 32'h0, "R1 ctrl", v, 32'h0);
    rd(4'h4, v); check(v == 32'h0, "R1 status", v, 32'h0);
    check(irq == 1'b0 && expire_pulse == 1'b0, "R1 outputs", {30'h0, irq, expire_pulse}, 32'h0);

    // R2: bit 29 dropped on readback; run stays 0 here so R3 load is exercised later
    wr(4'h0, 32'h7000_0005);
    rd(4'h0, v); check(v == 32'h5000_0005, "R2 readback", v, 32'h5000_0005);
    wr(4'h0, 32'h0);

    for (int i = 0; i < 4; i++) begin
      wr(4'h4, 32'h4000_0000);
      wr(4'h0, 32'h8000_0000 | (32'(VPER[i]) << 30) | VREL[i]);
      rd(4'h4, v); check(v == VREL[i], "R3 load", v, VREL[i]);
      for (int t = 1; t <= int'(VEXP[i]); t++) begin
        tick(p);
        check(p == (t == int'(VEXP[i])), "R5 expiry tick", {31'h0, p}, {31'h0, t == int'(VEXP[i])});
        if (t == 1 && VEXP[i] > 1) begin
          rd(4'h4, v); check(v == VREL[i] - 1, "R4 decrement", v, VREL[i] - 1);
        end
      end
      check(irq == 1'b1, "R5 irq set", {31'h0, irq}, 32'h1);
      rd(4'h4, v);
      if (VPER[i]) begin
        check(v == (32'h4000_0000 | VREL[i]), "R6 reload", v, 32'h4000_0000 | VREL[i]);
        rd(4'h0, v); check(v[31] == 1'b1, "R6 still running", v, 32'h8000_0000);
      end else begin
        check(v == 32'h4000_0000, "R7 count zero", v, 32'h4000_0000);
        rd(4'h0, v); check(v[31] == 1'b0, "R7 run cleared", v, 32'h0);
        tick(p); check(p == 1'b0, "R7 no further expiry", {31'h0, p}, 32'h0);
      end
      wr(4'h0, 32'h0);
    end

    // R9: write of 0 to bit 30 keeps the flag, write of 1 clears it
    wr(4'h4, 32'h0);
    check(irq == 1'b1, "R9 zero write no effect", {31'h0, irq}, 32'h1);
    wr(4'h4, 32'h4000_0000);
    check(irq == 1'b0, "R9 clear", {31'h0, irq}, 32'h0);
    rd(4'h4, v); check(v[30] == 1'b0, "R9 status bit", v, 32'h0);

    // R8: halt holds the count
    wr(4'h0, 32'h8000_0005);
    tick(p); tick(p);
    wr(4'h0, 32'h0);
    tick(p); check(p == 1'b0, "R8 no pulse halted", {31'h0, p}, 32'h0);
    tick(p); tick(p);
    rd(4'h4, v); check(v == 32'h3, "R8 count held", v, 32'h3);

    // R11: rewrite while running keeps count, new reload on next expiry
    wr(4'h0, 32'hC000_000A);
    tick(p); tick(p);
    wr(4'h0, 32'hC000_0003);
    rd(4'h4, v); check(v == 32'h8, "R11 no restart", v, 32'h8);
    for (int t = 1; t <= 8; t++) begin
      tick(p);
      check(p == (t == 8), "R11 expiry timing", {31'h0, p}, {31'h0, t == 8});
    end
    rd(4'h4, v); check(v[28:0] == 29'h3, "R11 new reload", v, 32'h3);

    // R12: tick colliding with control write is ignored
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hC000_0003; tick_en = 1'b1;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; tick_en = 1'b0;
    rd(4'h4, v); check(v[28:0] == 29'h3, "R12 tick ignored", v, 32'h3);

    // R10: expiry and clear in the same cycle, set wins
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h4000_0000);
    wr(4'h0, 32'hC000_0001);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h4000_0000; tick_en = 1'b1;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; tick_en = 1'b0;
    check(expire_pulse == 1'b1, "R10 pulse", {31'h0, expire_pulse}, 32'h1);
    check(irq == 1'b1, "R10 set wins", {31'h0, irq}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule